// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands (N = 8 by default) and returns the full 2N-bit product. It is built as a grid of full-adder rows. Each row adds one shifted bit-product vector to a running sum and carry pair in carry-save form, and a register follows every row. The final two-operand addition has no long ripple adder. It is split into further registered stages, and in each of them a carry advances by a single bit position. No stage holds a carry chain longer than two bit positions, so the clock period is set by roughly one full-adder delay.

Every row works on a different operand pair, so the block takes a new pair on every clock cycle. The multiplicand and multiplier ride down the carry-save rows next to the partial sums. Each product bit is kept in a vector that travels with its operation once it is final, so all 2N bits leave in the same cycle. A valid flag moves through the same number of stages as the data.

The stream interface has no ready signal and no back-pressure. The block always accepts `in_valid`. The consumer must take `out_p` in the cycle that `out_valid` is high, because the result is gone one cycle later.

Top module: `csa_array_mult`

## Requirements
- R1: When `out_valid` is high, `out_p` equals the unsigned 2N-bit product `in_mcand * in_mplier` of the pair that produced it.
- R2: A pair is accepted on every rising edge where `in_valid` is high, including back-to-back cycles. Each accepted pair yields exactly one result, and results leave in the order the pairs were accepted.
- R3: The latency `LATENCY` is fixed at 2N-1 cycles (15 for N = 8). This is one input register plus N-1 carry-save rows plus N-1 carry-resolution stages. A pair sampled on edge k is on the outputs after edge k+LATENCY-1.
- R4: Reset `rst` is synchronous and active high. After any rising edge with `rst` high, `out_valid` is low. Pairs that were in flight when reset was applied never appear at the output.
- R5: On a cycle where `in_valid` is low, the operand values are ignored, and `out_valid` is low LATENCY cycles later.
- R6: Extreme operands come out exact. A zero operand gives a zero product. Two all-ones operands give (2^N-1)^2, which is 0xFE01 for N = 8. 0x80 times 0x80 gives 0x4000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Marks the operand pair as a live operation |
| in_mcand | input | N | Unsigned multiplicand |
| in_mplier | input | N | Unsigned multiplier |
| out_valid | output | 1 | High for one cycle per finished product |
| out_p | output | 2N | Unsigned product, meaningful while `out_valid` is high |

## Verification
The bound properties assume that `rst` is high from time zero until the first edges have cleared the valid flags. They also assume the operands are known values whenever `in_valid` is high, and that no stall is ever needed, because the block has no ready. The bench holds reset from the start and drives only defined operand values, including the arbitrary values on idle cycles. It never expects a result to wait, and it samples `out_p` in the single cycle it is offered.

// File: rtl/csmul_pkg.sv
package csmul_pkg;

  // Cycles from operand capture to product: input register,
  // N-1 carry-save rows and N-1 carry-resolution stages.
  function automatic int unsigned pipe_depth(input int unsigned width);
    return 2 * width - 1;
  endfunction

  // Majority of three: carry output of a full adder.
  function automatic logic maj3(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction

endpackage

// File: rtl/csmul_cs_row.sv
// One registered carry-save row. It adds the bit-product vector for
// multiplier bit ROW into the sum/carry pair and retires one finished
// low product bit into the travelling result vector.
module csmul_cs_row #(
  parameter int unsigned N   = 8,
  parameter int unsigned ROW = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_i,
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     x_i,
  input  logic [N-1:0]     s_i,
  input  logic [N-1:0]     c_i,
  input  logic [2*N-1:0]   lo_i,
  output logic             v_o,
  output logic [N-1:0]     a_o,
  output logic [N-1:0]     x_o,
  output logic [N-1:0]     s_o,
  output logic [N-1:0]     c_o,
  output logic [2*N-1:0]   lo_o
);

  logic [N-1:0]   pp;
  logic [N:0]     pe;
  logic [N:0]     sum;
  logic [N-1:0]   cry;
  logic [2*N-1:0] lo_n;

  always_comb begin
    pp   = a_i & {N{x_i[ROW]}};
    // New bit-product sits one position above the current base.
    pe   = {pp, 1'b0};
    sum  = {1'b0, s_i} ^ {1'b0, c_i} ^ pe;
    cry  = (s_i & c_i) | (s_i & pe[N-1:0]) | (c_i & pe[N-1:0]);
    lo_n = lo_i;
    lo_n[ROW-1] = sum[0];
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    a_o  <= a_i;
    x_o  <= x_i;
    s_o  <= sum[N:1];
    c_o  <= cry;
    lo_o <= lo_n;
  end

endmodule

// File: rtl/csmul_res_stage.sv
// One registered carry-resolution stage: resolves one bit position
// of the remaining sum/carry pair (two in the first stage) and passes
// the carry on to the next stage.
module csmul_res_stage
  import csmul_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned STEP = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_i,
  input  logic [N-1:0]     s_i,
  input  logic [N-1:0]     c_i,
  input  logic             cy_i,
  input  logic [2*N-1:0]   lo_i,
  output logic             v_o,
  output logic [N-1:0]     s_o,
  output logic [N-1:0]     c_o,
  output logic             cy_o,
  output logic [2*N-1:0]   lo_o
);

  localparam bit          FIRST = (STEP == 1);
  localparam bit          LAST  = (STEP == N - 1);
  localparam int unsigned POS   = N - 1 + STEP;

  logic [N-1:0]   hs, hc;
  logic           low, cin, bit_r, cout;
  logic [2*N-1:0] lo_n;

  always_comb begin
    if (FIRST) begin
      low = s_i[0] ^ c_i[0];
      cin = s_i[0] & c_i[0];
      hs  = s_i >> 1;
      hc  = c_i >> 1;
    end else begin
      low = 1'b0;
      cin = cy_i;
      hs  = s_i;
      hc  = c_i;
    end
    bit_r = hs[0] ^ hc[0] ^ cin;
    cout  = maj3(hs[0], hc[0], cin);
    lo_n  = lo_i;
    if (FIRST) lo_n[POS-1] = low;
    lo_n[POS] = bit_r;
    if (LAST) lo_n[2*N-1] = cout;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    s_o  <= hs >> 1;
    c_o  <= hc >> 1;
    cy_o <= cout;
    lo_o <= lo_n;
  end

endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult
  import csmul_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [N-1:0]     in_mcand,
  input  logic [N-1:0]     in_mplier,
  output logic             out_valid,
  output logic [2*N-1:0]   out_p
);

  localparam int unsigned LATENCY = pipe_depth(N);

  // Input register (first pipeline stage).
  logic         v0;
  logic [N-1:0] a0, x0;

  always_ff @(posedge clk) begin
    if (rst) v0 <= 1'b0;
    else     v0 <= in_valid;
    a0 <= in_mcand;
    x0 <= in_mplier;
  end

  // Carry-save chain; index 0 is the first bit-product taken from the
  // input register, index k is the output of row k.
  logic           cs_v  [N];
  logic [N-1:0]   cs_a  [N];
  logic [N-1:0]   cs_x  [N];
  logic [N-1:0]   cs_s  [N];
  logic [N-1:0]   cs_c  [N];
  logic [2*N-1:0] cs_lo [N];

  assign cs_v[0]  = v0;
  assign cs_a[0]  = a0;
  assign cs_x[0]  = x0;
  assign cs_s[0]  = a0 & {N{x0[0]}};
  assign cs_c[0]  = '0;
  assign cs_lo[0] = '0;

  for (genvar k = 1; k < N; k++) begin : g_row
    csmul_cs_row #(.N(N), .ROW(k)) u_row (
      .clk  (clk),
      .rst  (rst),
      .v_i  (cs_v[k-1]),
      .a_i  (cs_a[k-1]),
      .x_i  (cs_x[k-1]),
      .s_i  (cs_s[k-1]),
      .c_i  (cs_c[k-1]),
      .lo_i (cs_lo[k-1]),
      .v_o  (cs_v[k]),
      .a_o  (cs_a[k]),
      .x_o  (cs_x[k]),
      .s_o  (cs_s[k]),
      .c_o  (cs_c[k]),
      .lo_o (cs_lo[k])
    );
  end

  // Carry-resolution chain; index 0 is the carry-save result.
  logic           rs_v  [N];
  logic [N-1:0]   rs_s  [N];
  logic [N-1:0]   rs_c  [N];
  logic           rs_cy [N];
  logic [2*N-1:0] rs_lo [N];

  assign rs_v[0]  = cs_v[N-1];
  assign rs_s[0]  = cs_s[N-1];
  assign rs_c[0]  = cs_c[N-1];
  assign rs_cy[0] = 1'b0;
  assign rs_lo[0] = cs_lo[N-1];

  for (genvar r = 1; r < N; r++) begin : g_res
    csmul_res_stage #(.N(N), .STEP(r)) u_res (
      .clk  (clk),
      .rst  (rst),
      .v_i  (rs_v[r-1]),
      .s_i  (rs_s[r-1]),
      .c_i  (rs_c[r-1]),
      .cy_i (rs_cy[r-1]),
      .lo_i (rs_lo[r-1]),
      .v_o  (rs_v[r]),
      .s_o  (rs_s[r]),
      .c_o  (rs_c[r]),
      .cy_o (rs_cy[r]),
      .lo_o (rs_lo[r])
    );
  end

  assign out_valid = rs_v[N-1];
  assign out_p     = rs_lo[N-1];

endmodule

// File: rtl/csa_array_mult_chk.sv
// Property checker bound to the multiplier. It keeps its own delay
// lines of accepted pairs and compares them against the output port.
module csa_array_mult_chk #(
  parameter int unsigned N   = 8,
  parameter int unsigned LAT = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [N-1:0]     in_mcand,
  input logic [N-1:0]     in_mplier,
  input logic             out_valid,
  input logic [2*N-1:0]   out_p
);

  logic [LAT-1:0] vline;
  logic [LAT-1:0] zline;
  logic [2*N-1:0] pline [LAT];
  logic [2*N-1:0] wide_a, wide_x;

  assign wide_a = {{N{1'b0}}, in_mcand};
  assign wide_x = {{N{1'b0}}, in_mplier};

  always_ff @(posedge clk) begin
    if (rst) begin
      vline <= '0;
      zline <= '0;
    end else begin
      vline <= {vline[LAT-2:0], in_valid};
      zline <= {zline[LAT-2:0], (in_mcand == '0) || (in_mplier == '0)};
    end
    pline[0] <= wide_a * wide_x;
    for (int i = 1; i < LAT; i++) pline[i] <= pline[i-1];
  end

  // R1: the offered product matches the pair it belongs to
  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_p == pline[LAT-1]));

  // R2, R3: every accepted pair surfaces exactly LAT cycles later
  assert_stream_R2: assert property (@(posedge clk) disable iff (rst)
    vline[LAT-1] |-> out_valid);

  // R5: an idle input cycle yields no output LAT cycles later
  assert_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    !vline[LAT-1] |-> !out_valid);

  // R4: reset leaves no valid result behind
  assert_reset_R4: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R6: a zero operand gives a zero product
  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zline[LAT-1]) |-> (out_p == '0));

endmodule

bind csa_array_mult csa_array_mult_chk #(.N(N), .LAT(LATENCY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_mcand  (in_mcand),
  .in_mplier (in_mplier),
  .out_valid (out_valid),
  .out_p     (out_p)
);

// File: tb/csa_array_mult_tb.sv
`timescale 1ns/1ps
module csa_array_mult_tb;

  localparam int unsigned N   = 8;
  localparam int unsigned LAT = 2 * N - 1;

  logic           clk       = 1'b0;
  logic           rst       = 1'b1;
  logic           in_valid  = 1'b0;
  logic [N-1:0]   in_mcand  = '0;
  logic [N-1:0]   in_mplier = '0;
  logic           out_valid;
  logic [2*N-1:0] out_p;

  always #5 clk = ~clk;

  csa_array_mult #(.N(N)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mcand  (in_mcand),
    .in_mplier (in_mplier),
    .out_valid (out_valid),
    .out_p     (out_p)
  );

  int             checks = 0;
  int             errors = 0;
  logic [LAT-1:0] hist   = '0;
  logic [2*N-1:0] exp_q [$];
  bit             tag_q [$];
  logic           seen_v;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One cycle: sample outputs at the falling edge, then drive inputs.
  task automatic step(input logic r, input logic v, input logic [N-1:0] a,
                      input logic [N-1:0] x, input bit tag);
    logic           exp_v;
    logic [2*N-1:0] exp_p;
    bit             t;
    logic [2*N-1:0] wa, wx;
    @(negedge clk);
    seen_v = out_valid;
    exp_v  = hist[LAT-1];
    check(out_valid === exp_v, exp_v ? "R2" : "R5", "out_valid",
          32'(out_valid), 32'(exp_v));
    if (exp_v && out_valid === 1'b1 && exp_q.size() > 0) begin
      exp_p = exp_q.pop_front();
      t     = tag_q.pop_front();
      check(out_p === exp_p, t ? "R6" : "R1", "out_p", 32'(out_p), 32'(exp_p));
    end
    rst       = r;
    in_valid  = v;
    in_mcand  = a;
    in_mplier = x;
    if (r) begin
      hist = '0;
      exp_q.delete();
      tag_q.delete();
    end else begin
      hist = {hist[LAT-2:0], v};
      if (v) begin
        wa = {{N{1'b0}}, a};
        wx = {{N{1'b0}}, x};
        exp_q.push_back(wa * wx);
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0, '0, 1'b0);
    check(exp_q.size() == 0, "R2", "products left undelivered",
          32'(exp_q.size()), 32'd0);
  endtask

  // R4: reset state and quiet output after reset
  task automatic t_reset_state();
    int hits;
    hits = 0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, '0, '0, 1'b0);
    for (int i = 0; i < LAT + 2; i++) begin
      step(1'b0, 1'b0, N'($urandom), N'($urandom), 1'b0);
      if (seen_v !== 1'b0) hits++;
    end
    check(hits == 0, "R4", "out_valid after reset", 32'(hits), 32'd0);
  endtask

  // R3: a lone pair appears exactly LAT cycles after it is driven
  task automatic t_latency();
    int first;
    first = 0;
    step(1'b0, 1'b1, 8'd13, 8'd11, 1'b0);
    for (int k = 1; k <= LAT + 3; k++) begin
      step(1'b0, 1'b0, '0, '0, 1'b0);
      if (seen_v === 1'b1 && first == 0) first = k;
    end
    check(first == LAT, "R3", "latency", 32'(first), 32'(LAT));
  endtask

  // R6: zero, all-ones and top-bit operands back to back
  task automatic t_extremes();
    step(1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1);
    step(1'b0, 1'b1, 8'h00, 8'hFF, 1'b1);
    step(1'b0, 1'b1, 8'hFF, 8'h00, 1'b1);
    step(1'b0, 1'b1, 8'hFF, 8'h01, 1'b1);
    step(1'b0, 1'b1, 8'h01, 8'hFF, 1'b1);
    step(1'b0, 1'b1, 8'h80, 8'h80, 1'b1);
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
    step(1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1);
    drain();
  endtask

  // R1, R2: a new random pair on every cycle
  task automatic t_stream();
    for (int i = 0; i < 300; i++)
      step(1'b0, 1'b1, N'($urandom), N'($urandom), 1'b0);
    drain();
  endtask

  // R5: idle cycles carry junk operands that must not surface
  task automatic t_bubbles();
    for (int i = 0; i < 200; i++)
      step(1'b0, 1'($urandom), N'($urandom), N'($urandom), 1'b0);
    drain();
  endtask

  // R4: reset with a full pipeline discards every pair in flight
  task automatic t_reset_flush();
    int hits;
    hits = 0;
    for (int i = 0; i < 10; i++)
      step(1'b0, 1'b1, N'($urandom), N'($urandom), 1'b0);
    step(1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0);
    for (int i = 0; i < LAT + 2; i++) begin
      step(1'b0, 1'b0, '0, '0, 1'b0);
      if (seen_v !== 1'b0) hits++;
    end
    check(hits == 0, "R4", "in-flight results after reset", 32'(hits), 32'd0);
  endtask

  initial begin
    t_reset_state();
    t_latency();
    t_extremes();
    t_stream();
    t_bubbles();
    t_reset_flush();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

endmodule